// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block stretches external memory cycles by a programmable number of wait clocks. A 16-bit control register holds one 5-bit wait count for each of the two external memory spaces: data memory X and program memory P. The bus master raises a cycle-start strobe and gives a space select in the same clock. The block looks up the wait count for that space and keeps its ready output low for that many clocks. In the last clock of the access it raises ready and a one-clock done pulse.

The control register sits on a simple register bus. A write strobe and a 16-bit data word load it. The read data port always shows the current contents. Bits that are not wait fields are stored as written and read back unchanged. They have no effect on timing.

The wait count is captured when a cycle starts. A later write to the register does not change an access that is already running. A new start strobe that arrives while an access is running is dropped.

Top module: `ext_wait_gen`

## Requirements
- R1: The control register is 16 bits wide. On a clock with `reg_wen` high, all 16 bits of `reg_wdata` are stored, and they appear on `reg_rdata` from the next clock onward. Without `reg_wen`, the register keeps its value.
- R2: Reset loads the value 0x03FF. Both wait fields hold 31, and bits 15:10 read zero.
- R3: An access with `cyc_space` = 0 (X data space) uses bits 4:0 as its wait count.
- R4: An access with `cyc_space` = 1 (program space) uses bits 9:5 as its wait count.
- R5: With a wait count N, an access lasts N+1 clocks, counting the start clock. `wait_rdy` is low in the first N of those clocks and high in the last one.
- R6: `done` is high for exactly one clock, the last clock of the access. With N = 0, `done` is high in the same clock as the accepted start.
- R7: The wait count is sampled in the clock the start is accepted. A register write in that clock, or during the access, changes only later accesses.
- R8: `busy` is high from the start clock through the done clock. A `cyc_start` seen while an access is still running is ignored. This includes a start in the done clock.
- R9: A `cyc_start` in the clock after a done clock begins a new access. A start held high continuously therefore gives back-to-back accesses of N+1 clocks each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| cyc_start | input | 1 | External bus cycle start strobe |
| cyc_space | input | 1 | Space of the cycle: 0 = X data, 1 = program |
| wait_rdy | output | 1 | Low while wait clocks remain, high otherwise |
| busy | output | 1 | Access in progress (start clock through done clock) |
| done | output | 1 | Last clock of the access |

## Verification
The bench builds the block with its default parameters: a 16-bit register, 5-bit wait fields and two spaces. It therefore runs the full 31-clock wait that reset leaves in place. It also covers the zero-wait case, where start and done share one clock, and different counts in the two fields at the same time. With these small field widths, the bench can reach every sampling corner within a short run: a write in the start clock, a write in the middle of an access, a start held through the done clock, and back-to-back starts.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    // Space codes carried on the select input
    typedef enum logic [0:0] {
        WSG_SPACE_X = 1'b0,
        WSG_SPACE_P = 1'b1
    } wsg_space_e;

    // Width of a select able to address n spaces (never below one bit)
    function automatic int unsigned wsg_sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned WAIT_W     = 5,
    parameter int unsigned NUM_SPACES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wen,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            reg_o,
    output logic [NUM_SPACES*WAIT_W-1:0] fields_o
);
    localparam int unsigned FIELDS_W = NUM_SPACES * WAIT_W;
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'({FIELDS_W{1'b1}});

    logic [DATA_W-1:0] ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wen) ctl_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RST_VAL;
        else        ctl_q <= ctl_d;
    end

    assign reg_o = ctl_q;

    // One wait field per space, packed upward from bit zero
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_field
        assign fields_o[g*WAIT_W +: WAIT_W] = ctl_q[g*WAIT_W +: WAIT_W];
    end

    // R1
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen |=> (ctl_q == $past(wdata)));

    // R1
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |=> $stable(ctl_q));

endmodule

// File: rtl/wsg_field_sel.sv
module wsg_field_sel #(
    parameter int unsigned WAIT_W     = 5,
    parameter int unsigned NUM_SPACES = 2,
    parameter int unsigned SEL_W      = 1
) (
    input  logic [NUM_SPACES*WAIT_W-1:0] fields_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [WAIT_W-1:0]            wait_o
);
    always_comb begin
        wait_o = '0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (sel_i == SEL_W'(i)) wait_o = fields_i[i*WAIT_W +: WAIT_W];
        end
    end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq #(
    parameter int unsigned WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ready_o
);
    typedef struct packed {
        logic              active;
        logic [WAIT_W-1:0] rem;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        accept = start_i & ~s_q.active;
        if (s_q.active) begin
            if (s_q.rem == '0) begin
                done_o   = 1'b1;
                s_d.active = 1'b0;
            end else begin
                s_d.rem = s_q.rem - 1'b1;
            end
        end else if (accept) begin
            if (wait_i == '0) begin
                done_o = 1'b1;
            end else begin
                s_d.active = 1'b1;
                s_d.rem    = wait_i - 1'b1;
            end
        end
        busy_o  = s_q.active | accept;
        ready_o = ~busy_o | done_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5
    countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.rem != '0) |=> (s_q.active && s_q.rem == $past(s_q.rem) - 1'b1));

    // R6
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !done_o) |=> s_q.active);

    // R7
    sample_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && start_i && wait_i != '0) |=> (s_q.rem == $past(wait_i) - 1'b1));

endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen
    import wsg_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned WAIT_W     = 5,
    parameter int unsigned NUM_SPACES = 2,
    parameter int unsigned SEL_W      = wsg_sel_bits(NUM_SPACES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cyc_start,
    input  logic [SEL_W-1:0]  cyc_space,
    output logic              wait_rdy,
    output logic              busy,
    output logic              done
);
    localparam int unsigned FIELDS_W = NUM_SPACES * WAIT_W;

    logic [FIELDS_W-1:0] fields;
    logic [WAIT_W-1:0]   wait_sel;

    wsg_ctrl_reg #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .NUM_SPACES(NUM_SPACES)) u_reg (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .wdata(reg_wdata),
        .reg_o(reg_rdata), .fields_o(fields)
    );

    wsg_field_sel #(.WAIT_W(WAIT_W), .NUM_SPACES(NUM_SPACES), .SEL_W(SEL_W)) u_sel (
        .fields_i(fields), .sel_i(cyc_space), .wait_o(wait_sel)
    );

    wsg_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(cyc_start), .wait_i(wait_sel),
        .busy_o(busy), .done_o(done), .ready_o(wait_rdy)
    );

    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wait_rdy && !done));

endmodule

// File: tb/ext_wait_gen_test.sv
`timescale 1ns/1ps
module ext_wait_gen_test;
    import wsg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wen;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        cyc_start;
    logic        cyc_space;
    logic        wait_rdy, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference state
    int ref_reg;
    bit ref_active;
    int ref_left;

    always #2.5 clk = ~clk;

    ext_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cyc_start(cyc_start), .cyc_space(cyc_space),
        .wait_rdy(wait_rdy), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int field_of(input int r, input bit sp);
        return sp ? ((r >> 5) & 31) : (r & 31);
    endfunction

    task automatic step(input bit wen, input int wd, input bit st, input bit sp, input string tag);
        bit acc, e_busy, e_done, e_rdy;
        int n;
        reg_wen = wen; reg_wdata = wd[15:0]; cyc_start = st; cyc_space = sp;
        #1;
        acc    = st && !ref_active;
        n      = field_of(ref_reg, sp);
        e_busy = ref_active || acc;
        e_done = ref_active ? (ref_left == 0) : (acc && n == 0);
        e_rdy  = !(e_busy && !e_done);
        chk(tag, "rdata", reg_rdata, ref_reg);
        chk(tag, "busy", busy, e_busy);
        chk(tag, "done", done, e_done);
        chk(tag, "wait_rdy", wait_rdy, e_rdy);
        @(posedge clk);
        if (ref_active) begin
            if (ref_left == 0) ref_active = 0;
            else ref_left--;
        end else if (acc && n != 0) begin
            ref_active = 1;
            ref_left = n - 1;
        end
        if (wen) ref_reg = wd & 16'hFFFF;
        @(negedge clk);
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, tag);
    endtask

    initial begin
        rst_n = 0; reg_wen = 0; reg_wdata = 0; cyc_start = 0; cyc_space = 0;
        ref_reg = 16'h03FF; ref_active = 0; ref_left = 0;
        repeat (3) @(negedge clk);
        // R2: reset contents visible while held in reset
        chk("R2", "rdata in reset", reg_rdata, 16'h03FF);
        chk("R2", "busy in reset", busy, 0);
        rst_n = 1;
        idle(2, "R2");

        // R2 R3: default 31 waits on X space
        step(0, 0, 1, WSG_SPACE_X, "R3");
        idle(34, "R5");

        // R1: clear everything, zero-wait accesses
        step(1, 16'h0000, 0, 0, "R1");
        step(0, 0, 1, WSG_SPACE_X, "R6");
        step(0, 0, 1, WSG_SPACE_P, "R6");
        idle(1, "R6");
        // R9: start held, N=0 -> done every clock
        for (int i = 0; i < 4; i++) step(0, 0, 1, WSG_SPACE_X, "R9");
        idle(1, "R9");

        // R1: X=3, P=7, upper bits stored
        step(1, 16'hB4E3, 0, 0, "R1");
        idle(1, "R1");
        step(0, 0, 1, WSG_SPACE_X, "R3");
        idle(6, "R3");
        step(0, 0, 1, WSG_SPACE_P, "R4");
        idle(10, "R4");

        // R8 R9: start held through a P access and its done clock
        for (int i = 0; i < 20; i++) step(0, 0, 1, WSG_SPACE_P, "R8");
        idle(10, "R8");

        // R7: write in the start clock does not affect this access
        step(1, 16'h0000, 1, WSG_SPACE_X, "R7");
        idle(6, "R7");
        step(0, 0, 1, WSG_SPACE_X, "R7");
        idle(1, "R7");

        // R7: write during an access
        step(1, 16'h0005, 0, 0, "R1");
        step(0, 0, 1, WSG_SPACE_X, "R7");
        step(0, 0, 0, 0, "R7");
        step(1, 16'h0001, 0, 0, "R7");
        idle(6, "R7");
        step(0, 0, 1, WSG_SPACE_X, "R7");
        idle(3, "R7");

        // R4 R6: P at max, X at zero
        step(1, 16'h03E0, 0, 0, "R1");
        step(0, 0, 1, WSG_SPACE_P, "R4");
        idle(34, "R4");
        step(0, 0, 1, WSG_SPACE_X, "R6");
        idle(2, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule